// File: doc/BRIEF.md
# Block-Granular Memory Copy Engine

This block copies one fixed-size block of 256 bytes from an external memory into one of three on-chip memories (secure instruction, non-secure instruction, data). Software sets up a source base address, split across a low and a high register, a source offset and a destination offset. It then writes a command word that names the block size and the target memory. The engine fetches the block as 32-bit words over a simple request/grant read port with in-order responses. It writes each returned word into the selected local memory, and it shows progress through an idle bit that software polls in the command register.

The source start address is 49 bits wide. The low base register supplies address bits 8 to 39. The high base register supplies bits 40 to 48. The source offset is added to that base. A start that is not on a 256-byte boundary, that carries past bit 48, or that names a size or target the engine cannot handle is finished at once and moves no data. Writing zero to the control register stops a transfer that is running.

Top module: `blkdma_top`

## Requirements
- R1: After reset the command register reads 0x00000001: idle is set and the size and target fields are zero. rd_req and lm_we stay low.
- R2: The source start address is ((BASE_HI[8:0] << 40) | (BASE_LO << 8)) + SRC_OFFS. This is a 49-bit byte address, and a carry out of bit 39 lands in the high field.
- R3: Each accepted command issues exactly 64 reads, with one read outstanding at a time. Read k asks for start + 4k. A request holds its address until rd_gnt, and its data comes back on rd_rvalid.
- R4: Each returned word is written once to the local memory at DST_OFFS + 4k. The writes go in ascending order, with lm_tgt equal to the command's target field and lm_wdata equal to the response data.
- R5: The register addresses are 0 command, 1 low base, 2 high base, 3 destination offset, 4 source offset, 5 control. In the command word, bit 0 is idle (read-only), bits 3:2 are the target (0 secure instruction, 1 non-secure instruction, 2 data) and bits 6:4 are the size code. Bits 6:2 read back as last accepted.
- R6: The idle bit reads 0 from the cycle after an accepted command up to and including the cycle of the 64th local write. It reads 1 in the cycle after that write.
- R7: A size code other than 6 completes at once: idle stays 1 and no read or write takes place.
- R8: A start address with any of bits 7:0 set, or whose sum exceeds 49 bits, completes at once without any read or write.
- R9: Target code 3 completes at once without any read or write.
- R10: A command written while a transfer is running is ignored. This includes a command in the cycle of the last local write: the fields read back unchanged and no further transfer starts.
- R11: Writing zero to the control register ends a running transfer. No local write happens in that cycle or afterwards, and idle reads 1 in the next cycle. A non-zero control write has no effect.
- R12: While idle the engine raises neither rd_req nor lm_we, and no transfer writes more than 64 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | 32 | Register read data (combinational) |
| rd_req | output | 1 | External read request |
| rd_addr | output | 49 | External read byte address |
| rd_gnt | input | 1 | Request accepted |
| rd_rvalid | input | 1 | Response data valid |
| rd_rdata | input | 32 | Response data |
| lm_we | output | 1 | Local memory write enable |
| lm_tgt | output | 2 | Local memory select |
| lm_addr | output | 16 | Local memory byte address |
| lm_wdata | output | 32 | Local memory write data |

## Verification
Two pairs of events can fall in the same cycle. In the first, a new command arrives in the cycle of the final local write. The bench watches for the write to offset DST_OFFS + 252 and drives a command with a different target in that cycle. It then expects idle one cycle later, the old fields in readback, and no read or write after that. In the second, a control write of zero can coincide with a response that is being written. The bench aborts in the middle of a transfer, under random grant stalls, and expects the local write count to freeze from the abort cycle on.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;
    localparam int REG_AW = 3;
    localparam int SIZE_W = 3;
    localparam int TGT_W  = 2;

    localparam logic [REG_AW-1:0] RA_CMD  = 3'd0;
    localparam logic [REG_AW-1:0] RA_BLO  = 3'd1;
    localparam logic [REG_AW-1:0] RA_BHI  = 3'd2;
    localparam logic [REG_AW-1:0] RA_DST  = 3'd3;
    localparam logic [REG_AW-1:0] RA_SRC  = 3'd4;
    localparam logic [REG_AW-1:0] RA_CTRL = 3'd5;

    localparam int CMD_IDLE_BIT = 0;
    localparam int CMD_TGT_LSB  = 2;
    localparam int CMD_SIZE_LSB = 4;

    localparam logic [TGT_W-1:0] TGT_RSVD = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } seq_st_e;
endpackage

// File: rtl/blkdma_regs.sv
module blkdma_regs
    import blkdma_pkg::*;
#(
    parameter int LO_W    = 32,
    parameter int HI_W    = 9,
    parameter int LMEM_AW = 16,
    parameter int SOFFS_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    input  logic [REG_AW-1:0]   reg_raddr,
    output logic [31:0]         reg_rdata,
    input  logic                busy,
    output logic                start,
    output logic                abort,
    output logic [LO_W-1:0]     base_lo,
    output logic [HI_W-1:0]     base_hi,
    output logic [LMEM_AW-1:0]  dst_offs,
    output logic [SOFFS_W-1:0]  src_offs,
    output logic [SIZE_W-1:0]   cmd_size,
    output logic [TGT_W-1:0]    cmd_tgt
);
    typedef struct packed {
        logic [LO_W-1:0]    base_lo;
        logic [HI_W-1:0]    base_hi;
        logic [LMEM_AW-1:0] dst;
        logic [SOFFS_W-1:0] src;
        logic [SIZE_W-1:0]  size;
        logic [TGT_W-1:0]   tgt;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d   = r_q;
        abort = reg_we && (reg_addr == RA_CTRL) && (reg_wdata == 32'd0);
        start = reg_we && (reg_addr == RA_CMD) && !busy;
        if (reg_we) begin
            case (reg_addr)
                RA_BLO: r_d.base_lo = reg_wdata[LO_W-1:0];
                RA_BHI: r_d.base_hi = reg_wdata[HI_W-1:0];
                RA_DST: r_d.dst     = reg_wdata[LMEM_AW-1:0];
                RA_SRC: r_d.src     = reg_wdata[SOFFS_W-1:0];
                RA_CMD: begin
                    if (start) begin
                        r_d.size = reg_wdata[CMD_SIZE_LSB +: SIZE_W];
                        r_d.tgt  = reg_wdata[CMD_TGT_LSB +: TGT_W];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_raddr)
            RA_CMD: begin
                reg_rdata[CMD_IDLE_BIT]              = !busy;
                reg_rdata[CMD_TGT_LSB +: TGT_W]      = r_q.tgt;
                reg_rdata[CMD_SIZE_LSB +: SIZE_W]    = r_q.size;
            end
            RA_BLO: reg_rdata[LO_W-1:0]    = r_q.base_lo;
            RA_BHI: reg_rdata[HI_W-1:0]    = r_q.base_hi;
            RA_DST: reg_rdata[LMEM_AW-1:0] = r_q.dst;
            RA_SRC: reg_rdata[SOFFS_W-1:0] = r_q.src;
            default: ;
        endcase
    end

    assign base_lo  = r_q.base_lo;
    assign base_hi  = r_q.base_hi;
    assign dst_offs = r_q.dst;
    assign src_offs = r_q.src;
    assign cmd_size = r_q.size;
    assign cmd_tgt  = r_q.tgt;
endmodule

// File: rtl/blkdma_seq.sv
module blkdma_seq
    import blkdma_pkg::*;
#(
    parameter int          ADDR_W      = 49,
    parameter int          LO_SHIFT    = 8,
    parameter int          HI_SHIFT    = 40,
    parameter int          BLOCK_BYTES = 256,
    parameter int          DATA_W      = 32,
    parameter int          LMEM_AW     = 16,
    parameter int          SOFFS_W     = 32,
    parameter int unsigned SIZE_CODE   = 6,
    localparam int LO_W = HI_SHIFT - LO_SHIFT,
    localparam int HI_W = ADDR_W - HI_SHIFT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                abort,
    input  logic [SIZE_W-1:0]   req_size,
    input  logic [TGT_W-1:0]    req_tgt,
    input  logic [LO_W-1:0]     base_lo,
    input  logic [HI_W-1:0]     base_hi,
    input  logic [SOFFS_W-1:0]  src_offs,
    input  logic [LMEM_AW-1:0]  dst_offs,
    output logic                rd_req,
    output logic [ADDR_W-1:0]   rd_addr,
    input  logic                rd_gnt,
    input  logic                rd_rvalid,
    input  logic [DATA_W-1:0]   rd_rdata,
    output logic                lm_we,
    output logic [TGT_W-1:0]    lm_tgt,
    output logic [LMEM_AW-1:0]  lm_addr,
    output logic [DATA_W-1:0]   lm_wdata,
    output logic                busy
);
    localparam int WB     = DATA_W / 8;
    localparam int WB_SH  = $clog2(WB);
    localparam int WORDS  = BLOCK_BYTES / WB;
    localparam int IDX_W  = $clog2(WORDS);
    localparam int BLK_SH = $clog2(BLOCK_BYTES);

    typedef struct packed {
        seq_st_e             st;
        logic [IDX_W-1:0]    idx;
        logic [ADDR_W-1:0]   src;
        logic [LMEM_AW-1:0]  dst;
        logic [TGT_W-1:0]    tgt;
    } seq_t;

    seq_t s_d, s_q;

    logic [ADDR_W-1:0] base_full;
    logic [ADDR_W:0]   start_sum;
    logic              cmd_ok;
    logic              last_word;

    always_comb begin
        base_full = {base_hi, base_lo, {LO_SHIFT{1'b0}}};
        start_sum = {1'b0, base_full} + (ADDR_W+1)'(src_offs);
        cmd_ok    = (req_size == SIZE_W'(SIZE_CODE)) &&
                    (req_tgt != TGT_RSVD) &&
                    !start_sum[ADDR_W] &&
                    (start_sum[BLK_SH-1:0] == '0);
        last_word = (s_q.idx == IDX_W'(WORDS - 1));

        s_d = s_q;
        case (s_q.st)
            ST_IDLE: begin
                if (start && cmd_ok) begin
                    s_d.st  = ST_REQ;
                    s_d.idx = '0;
                    s_d.src = start_sum[ADDR_W-1:0];
                    s_d.dst = dst_offs;
                    s_d.tgt = req_tgt;
                end
            end
            ST_REQ: begin
                if (rd_gnt) s_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (rd_rvalid) begin
                    if (last_word) begin
                        s_d.st = ST_IDLE;
                    end else begin
                        s_d.st  = ST_REQ;
                        s_d.idx = s_q.idx + IDX_W'(1);
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
        if (abort) begin
            s_d.st  = ST_IDLE;
            s_d.idx = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign rd_req   = (s_q.st == ST_REQ) && !abort;
    assign rd_addr  = s_q.src + ADDR_W'({s_q.idx, {WB_SH{1'b0}}});
    assign lm_we    = (s_q.st == ST_WAIT) && rd_rvalid && !abort;
    assign lm_tgt   = s_q.tgt;
    assign lm_addr  = s_q.dst + LMEM_AW'({s_q.idx, {WB_SH{1'b0}}});
    assign lm_wdata = rd_rdata;
    assign busy     = (s_q.st != ST_IDLE);
endmodule

// File: rtl/blkdma_top.sv
module blkdma_top
    import blkdma_pkg::*;
#(
    parameter int          ADDR_W      = 49,
    parameter int          LO_SHIFT    = 8,
    parameter int          HI_SHIFT    = 40,
    parameter int          BLOCK_BYTES = 256,
    parameter int          DATA_W      = 32,
    parameter int          LMEM_AW     = 16,
    parameter int          SOFFS_W     = 32,
    parameter int unsigned SIZE_CODE   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    input  logic [REG_AW-1:0]   reg_raddr,
    output logic [31:0]         reg_rdata,
    output logic                rd_req,
    output logic [ADDR_W-1:0]   rd_addr,
    input  logic                rd_gnt,
    input  logic                rd_rvalid,
    input  logic [DATA_W-1:0]   rd_rdata,
    output logic                lm_we,
    output logic [TGT_W-1:0]    lm_tgt,
    output logic [LMEM_AW-1:0]  lm_addr,
    output logic [DATA_W-1:0]   lm_wdata
);
    localparam int LO_W = HI_SHIFT - LO_SHIFT;
    localparam int HI_W = ADDR_W - HI_SHIFT;

    logic                eng_busy;
    logic                eng_start;
    logic                eng_abort;
    logic [LO_W-1:0]     cfg_base_lo;
    logic [HI_W-1:0]     cfg_base_hi;
    logic [LMEM_AW-1:0]  cfg_dst;
    logic [SOFFS_W-1:0]  cfg_src;
    logic [SIZE_W-1:0]   cfg_size;
    logic [TGT_W-1:0]    cfg_tgt;

    blkdma_regs #(
        .LO_W    (LO_W),
        .HI_W    (HI_W),
        .LMEM_AW (LMEM_AW),
        .SOFFS_W (SOFFS_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_raddr (reg_raddr),
        .reg_rdata (reg_rdata),
        .busy      (eng_busy),
        .start     (eng_start),
        .abort     (eng_abort),
        .base_lo   (cfg_base_lo),
        .base_hi   (cfg_base_hi),
        .dst_offs  (cfg_dst),
        .src_offs  (cfg_src),
        .cmd_size  (cfg_size),
        .cmd_tgt   (cfg_tgt)
    );

    logic [SIZE_W-1:0] start_size;
    logic [TGT_W-1:0]  start_tgt;
    // the sequencer judges the command word being written, not the stored one
    assign start_size = reg_wdata[CMD_SIZE_LSB +: SIZE_W];
    assign start_tgt  = reg_wdata[CMD_TGT_LSB +: TGT_W];

    blkdma_seq #(
        .ADDR_W      (ADDR_W),
        .LO_SHIFT    (LO_SHIFT),
        .HI_SHIFT    (HI_SHIFT),
        .BLOCK_BYTES (BLOCK_BYTES),
        .DATA_W      (DATA_W),
        .LMEM_AW     (LMEM_AW),
        .SOFFS_W     (SOFFS_W),
        .SIZE_CODE   (SIZE_CODE)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (eng_start),
        .abort     (eng_abort),
        .req_size  (start_size),
        .req_tgt   (start_tgt),
        .base_lo   (cfg_base_lo),
        .base_hi   (cfg_base_hi),
        .src_offs  (cfg_src),
        .dst_offs  (cfg_dst),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .rd_gnt    (rd_gnt),
        .rd_rvalid (rd_rvalid),
        .rd_rdata  (rd_rdata),
        .lm_we     (lm_we),
        .lm_tgt    (lm_tgt),
        .lm_addr   (lm_addr),
        .lm_wdata  (lm_wdata),
        .busy      (eng_busy)
    );

    logic unused_cfg;
    assign unused_cfg = ^{cfg_size, cfg_tgt};
endmodule

// File: rtl/blkdma_chk.sv
module blkdma_chk
    import blkdma_pkg::*;
#(
    parameter int ADDR_W  = 49,
    parameter int LMEM_AW = 16,
    parameter int WORDS   = 64,
    parameter int WB      = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               rd_req,
    input logic               rd_gnt,
    input logic [ADDR_W-1:0]  rd_addr,
    input logic               lm_we,
    input logic [LMEM_AW-1:0] lm_addr,
    input logic               reg_we,
    input logic [REG_AW-1:0]  reg_addr,
    input logic [31:0]        reg_wdata
);
    localparam int CNT_W = $clog2(WORDS) + 1;

    logic               abort_now;
    logic [CNT_W-1:0]   wr_cnt;
    logic [LMEM_AW-1:0] last_addr;

    assign abort_now = reg_we && (reg_addr == RA_CTRL) && (reg_wdata == 32'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_cnt    <= '0;
            last_addr <= '0;
        end else if (!busy) begin
            wr_cnt    <= '0;
        end else if (lm_we) begin
            wr_cnt    <= wr_cnt + CNT_W'(1);
            last_addr <= lm_addr;
        end
    end

    // R3: a pending request keeps its address until granted
    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_gnt && !abort_now) |=> (rd_req && $stable(rd_addr)) || abort_now);

    // R3: every read is word aligned
    a_r3_word_align: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_addr[$clog2(WB)-1:0] == '0));

    // R12: no traffic while idle
    a_r12_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_req && !lm_we));

    // R12: write count per transfer stays within one block
    a_r12_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        lm_we |-> (wr_cnt < CNT_W'(WORDS)));

    // R4: writes after the first step by one word
    a_r4_ascend: assert property (@(posedge clk) disable iff (!rst_n)
        (lm_we && busy && wr_cnt != '0) |-> (lm_addr == last_addr + LMEM_AW'(WB)));

    // R11: a zero control write leaves the engine idle next cycle
    a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        abort_now |=> !busy);

    // R11: no local write in the abort cycle
    a_r11_abort_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
        abort_now |-> !lm_we);
endmodule

bind blkdma_top blkdma_chk #(
    .ADDR_W  (ADDR_W),
    .LMEM_AW (LMEM_AW),
    .WORDS   (BLOCK_BYTES / (DATA_W / 8)),
    .WB      (DATA_W / 8)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (eng_busy),
    .rd_req    (rd_req),
    .rd_gnt    (rd_gnt),
    .rd_addr   (rd_addr),
    .lm_we     (lm_we),
    .lm_addr   (lm_addr),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata)
);

// File: tb/test_blkdma_top.sv
`timescale 1ns/1ps
module test_blkdma_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [2:0]  reg_raddr = 3'd0;
    logic [31:0] reg_rdata;
    logic        rd_req;
    logic [48:0] rd_addr;
    logic        rd_gnt;
    logic        rd_rvalid;
    logic [31:0] rd_rdata;
    logic        lm_we;
    logic [1:0]  lm_tgt;
    logic [15:0] lm_addr;
    logic [31:0] lm_wdata;

    always #4 clk = ~clk;

    blkdma_top i_blkdma_top (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_gnt(rd_gnt),
        .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata), .lm_we(lm_we),
        .lm_tgt(lm_tgt), .lm_addr(lm_addr), .lm_wdata(lm_wdata)
    );

    int vectors = 0;
    int miscompares = 0;

    function automatic logic [31:0] fmem(input logic [48:0] a);
        return (a[31:0] * 32'h9E37_79B1) ^ {23'd0, a[48:40]};
    endfunction

    // behavioural external memory: one-cycle response after grant
    logic [7:0] lfsr;
    logic       stall = 1'b0;
    assign rd_gnt = stall ? lfsr[0] : 1'b1;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_rvalid <= 1'b0;
            rd_rdata  <= 32'd0;
            lfsr      <= 8'h5A;
        end else begin
            rd_rvalid <= rd_req && rd_gnt;
            rd_rdata  <= fmem(rd_addr);
            lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    // expected transfer, followed by the monitor
    logic [48:0] exp_src;
    logic [15:0] exp_dst;
    logic [1:0]  exp_tgt;
    int          wr_k = 0;
    int          rd_k = 0;
    bit          last_pending = 1'b0;

    always @(negedge clk) begin
        #3;
        if (rst_n) begin
            if (last_pending) begin
                check(reg_rdata[0] == 1'b1, "R6", "idle after last write", reg_rdata[0], 1);
                last_pending = 1'b0;
            end
            if (rd_req && rd_gnt) begin
                check(rd_addr == exp_src + 49'(4 * rd_k), "R3", "read address",
                      rd_addr, exp_src + 49'(4 * rd_k));
                rd_k++;
            end
            if (lm_we) begin
                check(lm_addr == exp_dst + 16'(4 * wr_k), "R4", "write address",
                      lm_addr, exp_dst + 16'(4 * wr_k));
                check(lm_wdata == fmem(exp_src + 49'(4 * wr_k)), "R4", "write data",
                      lm_wdata, fmem(exp_src + 49'(4 * wr_k)));
                check(lm_tgt == exp_tgt, "R4", "write target", lm_tgt, exp_tgt);
                wr_k++;
                if (wr_k == 64) begin
                    check(reg_rdata[0] == 1'b0, "R6", "busy during last write", reg_rdata[0], 0);
                    last_pending = 1'b1;
                end
            end
        end
    end

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    function automatic logic [31:0] cmd_word(input logic [1:0] tgt, input logic [2:0] size);
        return {25'd0, size, tgt, 2'b00};
    endfunction

    function automatic bit addr_ok(input logic [8:0] hi, input logic [31:0] lo,
                                   input logic [31:0] src, output logic [48:0] s49);
        logic [49:0] s;
        s = {1'b0, hi, lo, 8'h00} + {18'd0, src};
        s49 = s[48:0];
        return !s[49] && (s[7:0] == 8'h00);
    endfunction

    task automatic start_only(input logic [8:0] hi, input logic [31:0] lo, input logic [31:0] src,
                              input logic [15:0] dst, input logic [1:0] tgt, input logic [2:0] size);
        logic [48:0] s49;
        void'(addr_ok(hi, lo, src, s49));
        exp_src = s49; exp_dst = dst; exp_tgt = tgt;
        wr_k = 0; rd_k = 0;
        reg_wr(3'd2, {23'd0, hi});
        reg_wr(3'd1, lo);
        reg_wr(3'd4, src);
        reg_wr(3'd3, {16'd0, dst});
        reg_wr(3'd0, cmd_word(tgt, size));
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 2000; n++) begin
            #1;
            if (reg_rdata[0]) break;
            @(negedge clk);
        end
        @(negedge clk); @(negedge clk); #1;
    endtask

    task automatic run_xfer(input logic [8:0] hi, input logic [31:0] lo, input logic [31:0] src,
                            input logic [15:0] dst, input logic [1:0] tgt, input logic [2:0] size,
                            input bit stall_in, input string tag);
        logic [48:0] s49;
        bit ok;
        ok = addr_ok(hi, lo, src, s49) && (size == 3'd6) && (tgt != 2'd3);
        stall = stall_in;
        start_only(hi, lo, src, dst, tgt, size);
        #1;
        check(reg_rdata[0] == !ok, tag, "idle after command", reg_rdata[0], !ok);
        check(reg_rdata[6:2] == {size, tgt}, "R5", "command readback", reg_rdata[6:2], {size, tgt});
        wait_idle();
        check(wr_k == (ok ? 64 : 0), tag, "local write count", wr_k, ok ? 64 : 0);
        check(rd_k == (ok ? 64 : 0), tag, "external read count", rd_k, ok ? 64 : 0);
    endtask

    initial begin
        reg_raddr = 3'd0;
        repeat (3) @(negedge clk);
        #1;
        check(reg_rdata == 32'h1, "R1", "command reset value", reg_rdata, 32'h1);
        check(!rd_req && !lm_we, "R1", "no traffic in reset", {rd_req, lm_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(reg_rdata == 32'h1, "R1", "command after reset", reg_rdata, 32'h1);
        @(negedge clk);

        // sweep of size code and target
        for (int t = 0; t < 4; t++) begin
            for (int sz = 0; sz < 8; sz++) begin
                run_xfer(9'h012, 32'h3456_789A, 32'h300, 16'h1234, 2'(t), 3'(sz), sz[0],
                         (t == 3) ? "R9" : ((sz != 6) ? "R7" : "R4"));
            end
        end

        // address formation and range/alignment
        run_xfer(9'h000, 32'h0000_0000, 32'h0,        16'h0000, 2'd2, 3'd6, 1'b0, "R2");
        run_xfer(9'h1FF, 32'hFFFF_FFFF, 32'h0,        16'hFF00, 2'd0, 3'd6, 1'b1, "R2");
        run_xfer(9'h000, 32'hFFFF_FFFF, 32'h100,      16'h0400, 2'd1, 3'd6, 1'b0, "R2");
        run_xfer(9'h155, 32'hAAAA_5555, 32'h7FFF_FF00, 16'h2000, 2'd2, 3'd6, 1'b1, "R2");
        run_xfer(9'h1FF, 32'hFFFF_FFFF, 32'h100,      16'h0000, 2'd0, 3'd6, 1'b0, "R8");
        run_xfer(9'h000, 32'h0000_0000, 32'h80,       16'h0000, 2'd0, 3'd6, 1'b0, "R8");
        run_xfer(9'h000, 32'h0000_0010, 32'h4,        16'h0000, 2'd1, 3'd6, 1'b0, "R8");

        // R10: command while busy
        stall = 1'b1;
        start_only(9'h003, 32'h0000_1000, 32'h0, 16'h0800, 2'd2, 3'd6);
        repeat (20) @(negedge clk);
        reg_wr(3'd0, cmd_word(2'd1, 3'd6));
        #1;
        check(reg_rdata[6:2] == {3'd6, 2'd2}, "R10", "fields kept while busy",
              reg_rdata[6:2], {3'd6, 2'd2});
        wait_idle();
        check(wr_k == 64, "R10", "busy command did not restart", wr_k, 64);

        // R10/R6: command in the cycle of the last write
        stall = 1'b0;
        start_only(9'h000, 32'h0000_0200, 32'h0, 16'h0100, 2'd1, 3'd6);
        for (int n = 0; n < 2000; n++) begin
            #1;
            if (lm_we && lm_addr == 16'h01FC) break;
            @(negedge clk);
        end
        reg_wr(3'd0, cmd_word(2'd0, 3'd6));
        #1;
        check(reg_rdata[0] == 1'b1, "R10", "idle after colliding command", reg_rdata[0], 1);
        check(reg_rdata[3:2] == 2'd1, "R10", "target kept", reg_rdata[3:2], 2'd1);
        repeat (10) @(negedge clk);
        #1;
        check(wr_k == 64 && rd_k == 64, "R10", "no extra traffic", {wr_k[15:0], rd_k[15:0]}, {16'd64, 16'd64});

        // R11: abort in mid-transfer with stalls
        begin
            int k;
            stall = 1'b1;
            start_only(9'h001, 32'h0000_0400, 32'h0, 16'h3000, 2'd0, 3'd6);
            for (int n = 0; n < 2000; n++) begin
                if (wr_k >= 10) break;
                @(negedge clk);
            end
            reg_wr(3'd5, 32'd0);
            #1;
            check(reg_rdata[0] == 1'b1, "R11", "idle after abort", reg_rdata[0], 1);
            k = wr_k;
            repeat (30) @(negedge clk);
            #1;
            check(wr_k == k && k < 64, "R11", "writes frozen by abort", wr_k, k);
        end
        run_xfer(9'h001, 32'h0000_0400, 32'h0, 16'h3000, 2'd0, 3'd6, 1'b0, "R11");

        // R11: non-zero control write has no effect
        stall = 1'b0;
        start_only(9'h000, 32'h0000_0500, 32'h0, 16'h4000, 2'd2, 3'd6);
        repeat (10) @(negedge clk);
        reg_wr(3'd5, 32'h5);
        #1;
        check(reg_rdata[0] == 1'b0, "R11", "still busy after non-zero control", reg_rdata[0], 0);
        wait_idle();
        check(wr_k == 64, "R11", "full block after non-zero control", wr_k, 64);

        // R12: quiet while idle
        repeat (5) @(negedge clk);
        #1;
        check(!rd_req && !lm_we, "R12", "no traffic idle", {rd_req, lm_we}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #1600000;
        vectors++;
        miscompares++;
        $display("FAIL watchdog R6 act=%0d exp=%0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule